// File: doc/BRIEF.md
# Synchronous Clock-Stop Gating Controller

This block sits between the clock generators and the output pins of a clock chip. It takes the ungated CPU clock and the ungated PCI clock and forwards them to the pins. Active-low stop requests halt groups of outputs at a fixed level. A request can arrive at any time. It is synchronized into the clock domain of the outputs it affects. The gate enable then changes only while the clock sits at the level the output will hold. Because of this, a stop never cuts a pulse short, and a release always starts with a full-width pulse.

The CPU outputs are differential pairs. While they are stopped, the true leg rests HIGH and the complement leg rests LOW. There are six ordinary PCI outputs, which stop LOW. Two further PCI outputs can each be set as free-running, and a free-running output ignores the PCI stop request. One shared pin has two roles, chosen by a configuration bit. In the first role it is the PCI stop input, with its pull-up on. In the second role it is an open-drain system-reset output, with its pull-up off. In that role it is driven as an output enable with constant data 0.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `cpu_stop_ni` is 0, after at most SYNC_STAGES+2 CPU clock cycles every `cpu_t_o` bit stays 1 and every `cpu_c_o` bit stays 0. While it is 1, `cpu_t_o` follows `cpu_clk_i` and `cpu_c_o` follows its inverse.
- R2: When `pin_role_stop_i`=1 and `pin_in_i`=0, after at most SYNC_STAGES+2 PCI clock cycles all six `pci_o` bits stay 0. When the pin is 1, each `pci_o` bit follows `pci_clk_i`.
- R3: A `pcif_o[k]` whose `pcif_free_i[k]`=1 keeps following `pci_clk_i` while the PCI stop request is active.
- R4: A `pcif_o[k]` whose `pcif_free_i[k]`=0 stops LOW and restarts together with `pci_o`.
- R5: When `pin_role_stop_i`=1, the pin acts as the stop input. `pin_oe_o`=0 and `pin_pullup_en_o`=1, whatever the value of `sys_rst_req_i`.
- R6: When `pin_role_stop_i`=0, `pin_in_i` has no effect and the PCI outputs run. `pin_pullup_en_o`=0, `pin_oe_o` equals `sys_rst_req_i`, and `pin_do_o` is 0.
- R7: Across stop and release, every high pulse on a PCI output lasts half a PCI period. Every low pulse on a CPU true output, and every high pulse on a CPU complement output, lasts half a CPU period.
- R8: While `rst_ni`=0, all gates are open, so the outputs follow their clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Ungated CPU clock |
| pci_clk_i | input | 1 | Ungated PCI clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | CPU stop request, active low, asynchronous |
| pin_in_i | input | 1 | Value received on the shared stop/reset pin |
| pin_role_stop_i | input | 1 | Role of the shared pin: 1 = stop input, 0 = reset output |
| sys_rst_req_i | input | 1 | Request to pull the reset output low |
| pcif_free_i | input | PCI_FREE | Free-running selection for each selectable PCI output |
| cpu_t_o | output | CPU_PAIRS | CPU true legs |
| cpu_c_o | output | CPU_PAIRS | CPU complement legs |
| pci_o | output | PCI_GATED | Stoppable PCI outputs |
| pcif_o | output | PCI_FREE | Selectable free-running PCI outputs |
| pin_oe_o | output | 1 | Output enable of the shared pin driver |
| pin_do_o | output | 1 | Data value of the shared pin driver (always 0) |
| pin_pullup_en_o | output | 1 | Internal pull-up enable of the shared pin |

## Verification
The role change of the shared pin and the PCI stop can act in the same cycle. This happens when the pin is held low, which stops the PCI outputs, and the role bit then drops to reset-output mode while a reset request is raised at the same moment. The bench provokes exactly this case. It checks that the driver enable turns on at once and that the pull-up turns off. It then checks that the PCI outputs restart within the synchronizer latency, with only full-width pulses. Switching the role back while the pin is still low must drop the driver enable and stop the PCI outputs again. The CPU stop and the PCI stop are also asserted together, and each group is judged separately.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    GATE_STOP_LOW = 2'd0,
    GATE_DIFF     = 2'd1
  } gate_mode_e;

  // Single-ended output that rests LOW while stopped.
  function automatic logic gate_low(input logic clk, input logic en);
    return clk & en;
  endfunction

  // True leg of a pair: rests HIGH while stopped.
  function automatic logic gate_true(input logic clk, input logic en);
    return clk | ~en;
  endfunction

  // Complement leg of a pair: rests LOW while stopped.
  function automatic logic gate_comp(input logic clk, input logic en);
    return ~clk & en;
  endfunction

  // Run decision for one output: a free output never stops.
  function automatic logic run_decide(input logic run_req, input logic free);
    return run_req | free;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  // The chain resets to 1, meaning "run".
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter gate_mode_e MODE = GATE_STOP_LOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_req_i,
  input  logic free_i,
  output logic en_o,
  output logic out_o,
  output logic out_n_o
);
  logic en_q;
  logic run_d;

  assign run_d = run_decide(run_req_i, free_i);

  generate
    if (MODE == GATE_STOP_LOW) begin : g_low
      // The enable is loaded while the clock is low, which is the rest level.
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b1;
        else         en_q <= run_d;
      end
      assign out_o   = gate_low(clk_i, en_q);
      assign out_n_o = 1'b0;
    end else begin : g_diff
      // The enable is loaded while the clock is high. In that phase the true
      // leg is at 1 and the complement leg is at 0, the rest levels of both.
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b1;
        else         en_q <= run_d;
      end
      assign out_o   = gate_true(clk_i, en_q);
      assign out_n_o = gate_comp(clk_i, en_q);
    end
  endgenerate

  assign en_o = en_q;
endmodule

// File: rtl/clkstop_pinrole.sv
module clkstop_pinrole (
  input  logic pin_in_i,
  input  logic role_stop_i,
  input  logic rst_req_i,
  output logic stop_n_o,
  output logic oe_o,
  output logic do_o,
  output logic pullup_en_o
);
  // In reset-output mode the received pin value is ignored and reads as "run".
  assign stop_n_o    = role_stop_i ? pin_in_i : 1'b1;
  assign oe_o        = ~role_stop_i & rst_req_i;
  assign do_o        = 1'b0;
  assign pullup_en_o = role_stop_i;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int CPU_PAIRS   = 2,
  parameter int PCI_GATED   = 6,
  parameter int PCI_FREE    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 cpu_clk_i,
  input  logic                 pci_clk_i,
  input  logic                 rst_ni,
  input  logic                 cpu_stop_ni,
  input  logic                 pin_in_i,
  input  logic                 pin_role_stop_i,
  input  logic                 sys_rst_req_i,
  input  logic [PCI_FREE-1:0]  pcif_free_i,
  output logic [CPU_PAIRS-1:0] cpu_t_o,
  output logic [CPU_PAIRS-1:0] cpu_c_o,
  output logic [PCI_GATED-1:0] pci_o,
  output logic [PCI_FREE-1:0]  pcif_o,
  output logic                 pin_oe_o,
  output logic                 pin_do_o,
  output logic                 pin_pullup_en_o
);
  // Named internal events, observed by the checker.
  logic                 pci_stop_n_w;
  logic                 cpu_run_w;
  logic                 pci_run_w;
  logic [CPU_PAIRS-1:0] cpu_en_w;
  logic [PCI_GATED-1:0] pci_en_w;
  logic [PCI_FREE-1:0]  pcif_en_w;
  logic [PCI_GATED-1:0] pci_unused_w;
  logic [PCI_FREE-1:0]  pcif_unused_w;

  clkstop_pinrole u_role (
    .pin_in_i    (pin_in_i),
    .role_stop_i (pin_role_stop_i),
    .rst_req_i   (sys_rst_req_i),
    .stop_n_o    (pci_stop_n_w),
    .oe_o        (pin_oe_o),
    .do_o        (pin_do_o),
    .pullup_en_o (pin_pullup_en_o)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk_i   (cpu_clk_i),
    .rst_ni  (rst_ni),
    .async_i (cpu_stop_ni),
    .sync_o  (cpu_run_w)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
    .clk_i   (pci_clk_i),
    .rst_ni  (rst_ni),
    .async_i (pci_stop_n_w),
    .sync_o  (pci_run_w)
  );

  genvar gi;
  generate
    for (gi = 0; gi < CPU_PAIRS; gi++) begin : g_cpu
      clkstop_gate #(.MODE(GATE_DIFF)) u_gate (
        .clk_i     (cpu_clk_i),
        .rst_ni    (rst_ni),
        .run_req_i (cpu_run_w),
        .free_i    (1'b0),
        .en_o      (cpu_en_w[gi]),
        .out_o     (cpu_t_o[gi]),
        .out_n_o   (cpu_c_o[gi])
      );
    end

    for (gi = 0; gi < PCI_GATED; gi++) begin : g_pci
      clkstop_gate #(.MODE(GATE_STOP_LOW)) u_gate (
        .clk_i     (pci_clk_i),
        .rst_ni    (rst_ni),
        .run_req_i (pci_run_w),
        .free_i    (1'b0),
        .en_o      (pci_en_w[gi]),
        .out_o     (pci_o[gi]),
        .out_n_o   (pci_unused_w[gi])
      );
    end

    for (gi = 0; gi < PCI_FREE; gi++) begin : g_pcif
      clkstop_gate #(.MODE(GATE_STOP_LOW)) u_gate (
        .clk_i     (pci_clk_i),
        .rst_ni    (rst_ni),
        .run_req_i (pci_run_w),
        .free_i    (pcif_free_i[gi]),
        .en_o      (pcif_en_w[gi]),
        .out_o     (pcif_o[gi]),
        .out_n_o   (pcif_unused_w[gi])
      );
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{pci_unused_w, pcif_unused_w};
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int CPU_PAIRS = 2,
  parameter int PCI_GATED = 6,
  parameter int PCI_FREE  = 2
) (
  input logic                 cpu_clk_i,
  input logic                 pci_clk_i,
  input logic                 rst_ni,
  input logic                 pin_role_stop_i,
  input logic                 sys_rst_req_i,
  input logic [PCI_FREE-1:0]  pcif_free_i,
  input logic [CPU_PAIRS-1:0] cpu_t_o,
  input logic [CPU_PAIRS-1:0] cpu_c_o,
  input logic [PCI_GATED-1:0] pci_o,
  input logic [PCI_FREE-1:0]  pcif_o,
  input logic                 pin_oe_o,
  input logic                 pin_pullup_en_o,
  input logic [CPU_PAIRS-1:0] cpu_en_w,
  input logic [PCI_GATED-1:0] pci_en_w,
  input logic [PCI_FREE-1:0]  pcif_en_w
);
  genvar gk;
  generate
    for (gk = 0; gk < CPU_PAIRS; gk++) begin : g_cpu_a
      // R1: in the low phase just before a rising edge, a closed gate holds the pair at its rest levels.
      p_cpu_rest_levels_r1: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
        !cpu_en_w[gk] |-> (cpu_t_o[gk] && !cpu_c_o[gk]));
    end
    for (gk = 0; gk < PCI_GATED; gk++) begin : g_pci_a
      // R2: a closed gate keeps the PCI output low through the high phase.
      p_pci_rest_low_r2: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
        !pci_en_w[gk] |-> !pci_o[gk]);
    end
    for (gk = 0; gk < PCI_FREE; gk++) begin : g_pcif_a
      // R3: an output that was free-running at the previous falling edge is high in this high phase.
      p_free_keeps_running_r3: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
        (pcif_free_i[gk] && $past(pcif_free_i[gk])) |-> pcif_o[gk]);
      // R4: a selectable output whose gate is closed rests low.
      p_selectable_rest_low_r4: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
        !pcif_en_w[gk] |-> !pcif_o[gk]);
    end
  endgenerate

  // R2: all six gated PCI outputs open and close as one group.
  p_pci_group_r2: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    ($countones(pci_en_w) == 0) || ($countones(pci_en_w) == PCI_GATED));

  // R5: in stop-input role the pin is never driven.
  p_no_drive_in_stop_role_r5: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    pin_role_stop_i |-> !pin_oe_o);

  // R6: whenever the driver is on, the pull-up is off.
  p_pullup_off_when_driving_r6: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    pin_oe_o |-> !pin_pullup_en_o);

  // R6: in reset role the driver enable follows the request.
  p_oe_follows_req_r6: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    !pin_role_stop_i |-> (pin_oe_o == sys_rst_req_i));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .CPU_PAIRS (CPU_PAIRS),
  .PCI_GATED (PCI_GATED),
  .PCI_FREE  (PCI_FREE)
) u_chk (
  .cpu_clk_i       (cpu_clk_i),
  .pci_clk_i       (pci_clk_i),
  .rst_ni          (rst_ni),
  .pin_role_stop_i (pin_role_stop_i),
  .sys_rst_req_i   (sys_rst_req_i),
  .pcif_free_i     (pcif_free_i),
  .cpu_t_o         (cpu_t_o),
  .cpu_c_o         (cpu_c_o),
  .pci_o           (pci_o),
  .pcif_o          (pcif_o),
  .pin_oe_o        (pin_oe_o),
  .pin_pullup_en_o (pin_pullup_en_o),
  .cpu_en_w        (cpu_en_w),
  .pci_en_w        (pci_en_w),
  .pcif_en_w       (pcif_en_w)
);

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
  localparam int CP = 2;
  localparam int PG = 6;
  localparam int PF = 2;
  localparam time CPU_HALF = 5;
  localparam time PCI_HALF = 15;

  logic cpu_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1;
  logic pin_in = 1'b1;
  logic role_stop = 1'b1;
  logic rst_req = 1'b0;
  logic [PF-1:0] free_cfg = '1;
  logic [CP-1:0] cpu_t, cpu_c;
  logic [PG-1:0] pci;
  logic [PF-1:0] pcif;
  logic pin_oe, pin_do, pin_pu;

  int checks = 0;
  int failures = 0;
  int bad_pci_w = 0;
  int bad_cpu_w = 0;
  bit mon_on = 1'b0;
  time pci_rise = 0;
  time cpu_fall = 0;
  time cpuc_rise = 0;

  always #(CPU_HALF) cpu_clk = ~cpu_clk;
  always #(PCI_HALF) pci_clk = ~pci_clk;

  clkstop_ctrl #(.CPU_PAIRS(CP), .PCI_GATED(PG), .PCI_FREE(PF), .SYNC_STAGES(2)) dut_i (
    .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .rst_ni(rst_n),
    .cpu_stop_ni(cpu_stop_n), .pin_in_i(pin_in), .pin_role_stop_i(role_stop),
    .sys_rst_req_i(rst_req), .pcif_free_i(free_cfg),
    .cpu_t_o(cpu_t), .cpu_c_o(cpu_c), .pci_o(pci), .pcif_o(pcif),
    .pin_oe_o(pin_oe), .pin_do_o(pin_do), .pin_pullup_en_o(pin_pu));

  // R7 pulse-width monitors.
  always @(posedge pci[0]) pci_rise = $time;
  always @(negedge pci[0]) if (mon_on && ($time - pci_rise) != PCI_HALF) bad_pci_w++;
  always @(negedge cpu_t[0]) cpu_fall = $time;
  always @(posedge cpu_t[0]) if (mon_on && ($time - cpu_fall) != CPU_HALF) bad_cpu_w++;
  always @(posedge cpu_c[0]) cpuc_rise = $time;
  always @(negedge cpu_c[0]) if (mon_on && ($time - cpuc_rise) != CPU_HALF) bad_cpu_w++;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Samples the PCI outputs in the middle of a high phase and of the next low phase.
  task automatic sample_pci(output logic [PG-1:0] g_hi, output logic [PG-1:0] g_lo,
                            output logic [PF-1:0] f_hi, output logic [PF-1:0] f_lo);
    @(posedge pci_clk); #7; g_hi = pci; f_hi = pcif;
    @(negedge pci_clk); #7; g_lo = pci; f_lo = pcif;
  endtask

  task automatic sample_cpu(output logic [CP-1:0] t_hi, output logic [CP-1:0] t_lo,
                            output logic [CP-1:0] c_hi, output logic [CP-1:0] c_lo);
    @(posedge cpu_clk); #2; t_hi = cpu_t; c_hi = cpu_c;
    @(negedge cpu_clk); #2; t_lo = cpu_t; c_lo = cpu_c;
  endtask

  task automatic wait_pci(input int n);
    repeat (n) @(posedge pci_clk);
  endtask

  task automatic expect_pci(input string req, input logic [PG-1:0] g_run, input logic [PF-1:0] f_run);
    logic [PG-1:0] gh, gl;
    logic [PF-1:0] fh, fl;
    sample_pci(gh, gl, fh, fl);
    check(req, "pci high phase", 32'(gh), 32'(g_run));
    check(req, "pci low phase", 32'(gl), 32'(0));
    check(req, "pcif high phase", 32'(fh), 32'(f_run));
    check(req, "pcif low phase", 32'(fl), 32'(0));
  endtask

  task automatic expect_cpu(input string req, input bit running);
    logic [CP-1:0] th, tl, ch, cl;
    sample_cpu(th, tl, ch, cl);
    check(req, "cpu true high phase", 32'(th), 32'({CP{1'b1}}));
    check(req, "cpu true low phase", 32'(tl), running ? 32'(0) : 32'({CP{1'b1}}));
    check(req, "cpu comp high phase", 32'(ch), 32'(0));
    check(req, "cpu comp low phase", 32'(cl), running ? 32'({CP{1'b1}}) : 32'(0));
  endtask

  task automatic t_reset_state();
    // R8: gates open while reset is held.
    expect_pci("R8", '1, '1);
    expect_cpu("R8", 1'b1);
    check("R5", "oe in reset", 32'(pin_oe), 32'(0));
    check("R5", "pullup in reset", 32'(pin_pu), 32'(1));
  endtask

  task automatic t_cpu_stop();
    #3 cpu_stop_n = 1'b0;
    repeat (6) @(posedge cpu_clk);
    expect_cpu("R1", 1'b0);
    expect_pci("R1", '1, '1);
    #1 cpu_stop_n = 1'b1;
    repeat (6) @(posedge cpu_clk);
    expect_cpu("R1", 1'b1);
  endtask

  task automatic t_pci_stop_free();
    free_cfg = 2'b11;
    #4 pin_in = 1'b0;
    wait_pci(6);
    expect_pci("R2", '0, 2'b11);
    check("R3", "pcif both free", 32'(pcif === 2'b11 || pcif === 2'b00), 32'(1));
    expect_cpu("R2", 1'b1);
    #2 pin_in = 1'b1;
    wait_pci(6);
    expect_pci("R2", '1, '1);
  endtask

  task automatic t_pci_stop_mixed();
    free_cfg = 2'b01;
    wait_pci(2);
    #5 pin_in = 1'b0;
    wait_pci(6);
    expect_pci("R4", '0, 2'b01);
    #9 pin_in = 1'b1;
    wait_pci(6);
    expect_pci("R4", '1, '1);
    free_cfg = 2'b11;
    wait_pci(2);
  endtask

  task automatic t_reset_role();
    role_stop = 1'b0;
    pin_in = 1'b0;
    rst_req = 1'b0;
    #1;
    check("R6", "oe idle", 32'(pin_oe), 32'(0));
    check("R6", "pullup off", 32'(pin_pu), 32'(0));
    check("R6", "data zero", 32'(pin_do), 32'(0));
    free_cfg = 2'b00;
    wait_pci(6);
    expect_pci("R6", '1, '1);
    rst_req = 1'b1;
    #1 check("R6", "oe on request", 32'(pin_oe), 32'(1));
    rst_req = 1'b0;
    role_stop = 1'b1;
    rst_req = 1'b1;
    #1 check("R5", "oe blocked in stop role", 32'(pin_oe), 32'(0));
    check("R5", "pullup on", 32'(pin_pu), 32'(1));
    rst_req = 1'b0;
    pin_in = 1'b1;
    free_cfg = 2'b11;
    wait_pci(6);
  endtask

  task automatic t_role_and_stop_together();
    free_cfg = 2'b00;
    #3 pin_in = 1'b0;
    cpu_stop_n = 1'b0;
    wait_pci(6);
    expect_pci("R2", '0, '0);
    expect_cpu("R1", 1'b0);
    role_stop = 1'b0;
    rst_req = 1'b1;
    #1 check("R6", "oe same moment", 32'(pin_oe), 32'(1));
    check("R6", "pullup same moment", 32'(pin_pu), 32'(0));
    wait_pci(6);
    expect_pci("R6", '1, '1);
    expect_cpu("R1", 1'b0);
    role_stop = 1'b1;
    #1 check("R5", "oe dropped on return", 32'(pin_oe), 32'(0));
    wait_pci(6);
    expect_pci("R2", '0, '0);
    rst_req = 1'b0;
    pin_in = 1'b1;
    cpu_stop_n = 1'b1;
    free_cfg = 2'b11;
    wait_pci(6);
    expect_pci("R2", '1, '1);
    expect_cpu("R1", 1'b1);
  endtask

  task automatic t_pulse_widths();
    check("R7", "pci pulse widths", 32'(bad_pci_w), 32'(0));
    check("R7", "cpu pulse widths", 32'(bad_cpu_w), 32'(0));
  endtask

  initial begin
    #40;
    t_reset_state();
    @(negedge cpu_clk);
    rst_n = 1'b1;
    wait_pci(3);
    mon_on = 1'b1;
    t_cpu_stop();
    t_pci_stop_free();
    t_pci_stop_mixed();
    t_reset_role();
    t_role_and_stop_together();
    t_pulse_widths();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule